// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block gathers up to thirty interrupt sources into four byte-wide groups: a low-rank group A, a high-rank group B, a DMA group with six sources, and a fast-interrupt group. Each group has a raw status byte, a mask byte and a request byte, which is the status gated by the mask. Group A sources are captured into sticky status bits that software clears by writing ones. The other three groups pass their inputs straight through as level-sensitive status.

Software reaches every register over a simple byte-wide bus with an address, write data, a write strobe and registered read data. A vector register gives the global number of the one pending request that wins arbitration. Software reads it to find out which source to service, with no need to scan the groups itself. Two output lines go to the processor: a normal interrupt line driven by groups A, B and DMA, and a fast-interrupt line driven by the fast group.

Top module: `birq_ctrl`

## Requirements
- R1: After reset all four mask bytes are zero, `irq_o` and `fiq_o` are low and `bus_rdata` is zero.
- R2: Group register blocks sit at 0x10 (A), 0x20 (B), 0x30 (DMA) and 0x40 (fast). Within a block, offset 0x0 reads status, 0x4 reads request and takes clear writes, and 0x8 is the read/write mask. The vector is read at 0x00 and unmapped addresses read zero. Read data appears on `bus_rdata` one clock after the address is presented.
- R3: A group's request byte equals its status AND its mask, so a source whose mask bit is 0 shows in status but raises no output.
- R4: Group A status bits are set by a high input and stay set after the input falls. Writing 1 to a bit at offset 0x4 clears that bit, except when the input is high in the same cycle, in which case the bit stays set.
- R5: Groups B, DMA and fast report their inputs directly as status, and writes to their offset 0x4 change nothing.
- R6: DMA bits 7 and 6 always read as 0 in status, mask and request, even after writing 0xFF to the DMA mask.
- R7: The vector reports group B before DMA and DMA before group A, and reads 0 when none of them has a request. Numbering is bit+0 for A, bit+8 for B and bit+16 for DMA. Fast-group requests never appear in the vector.
- R8: Inside group B the winning bit, from highest rank down, is 2, 3, 5, 7, 6, 0, 1, 4.
- R9: Inside the DMA group the winning bit, from highest rank down, is 0, 1, 2, 3, 5, 4.
- R10: Inside group A the winning bit, from highest rank down, is 7, 5, 3, 6, 2, 0, 1, 4. A winning bit 0 therefore gives vector 0.
- R11: `irq_o` is high exactly when any request bit of A, B or DMA is set. `fiq_o` is high exactly when any fast-group request bit is set.
- R12: Reading the vector changes no state, so repeated reads return the same value and the status is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| src_a_i | input | 8 | Group A sources (sticky) |
| src_b_i | input | 8 | Group B sources (level) |
| src_dma_i | input | 6 | DMA sources (level) |
| src_fiq_i | input | 8 | Fast-group sources (level) |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
A corrupted mask byte or sticky status bit in group A shows up on `irq_o` in the same cycle. It also shows up on `bus_rdata` one clock after the affected register is addressed. A wrong rank order inside the resolver can only be seen through the vector read. The bench therefore applies combinations of sources that tell neighbouring ranks apart and compares the vector one clock after each read. A clear that is lost or applied wrongly stays visible until the next clear write, so a status read just after each clear exposes it.

// File: rtl/birq_pkg.sv
package birq_pkg;
  localparam int NUM_GRP = 4;
  localparam int GRP_W   = 8;
  localparam int SEL_W   = $clog2(GRP_W);

  localparam int GRP_A   = 0;
  localparam int GRP_B   = 1;
  localparam int GRP_DMA = 2;
  localparam int GRP_FIQ = 3;

  // Rank tables: field [2:0] holds the highest-ranked bit
  localparam logic [GRP_W*SEL_W-1:0] RANK_B   = {3'd4, 3'd1, 3'd0, 3'd6, 3'd7, 3'd5, 3'd3, 3'd2};
  localparam logic [GRP_W*SEL_W-1:0] RANK_DMA = {3'd4, 3'd7, 3'd6, 3'd5, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [GRP_W*SEL_W-1:0] RANK_A   = {3'd4, 3'd1, 3'd0, 3'd2, 3'd6, 3'd3, 3'd5, 3'd7};

  localparam logic [7:0] NUM_BASE_A   = 8'd0;
  localparam logic [7:0] NUM_BASE_B   = 8'd8;
  localparam logic [7:0] NUM_BASE_DMA = 8'd16;

  // Bits implemented in each group
  function automatic logic [GRP_W-1:0] grp_used(input int g);
    return (g == GRP_DMA) ? 8'h3F : 8'hFF;
  endfunction

  // Only group A keeps sticky status
  function automatic bit grp_sticky(input int g);
    return g == GRP_A;
  endfunction

  // Ranked pick: returns bit index of the winner; walks lowest rank first
  function automatic logic [SEL_W-1:0] rank_pick(input logic [GRP_W-1:0] req,
                                                 input logic [GRP_W*SEL_W-1:0] order);
    logic [SEL_W-1:0] sel;
    sel = '0;
    for (int i = GRP_W - 1; i >= 0; i--) begin
      if (req[order[i*SEL_W +: SEL_W]]) sel = order[i*SEL_W +: SEL_W];
    end
    return sel;
  endfunction

  // Sticky status update: live input wins over a clear in the same cycle
  function automatic logic [GRP_W-1:0] sticky_next(input logic [GRP_W-1:0] cur,
                                                   input logic [GRP_W-1:0] clr,
                                                   input logic [GRP_W-1:0] src);
    return (cur & ~clr) | src;
  endfunction
endpackage

// File: rtl/birq_group.sv
module birq_group
  import birq_pkg::*;
#(
  parameter bit              STICKY = 1'b0,
  parameter logic [GRP_W-1:0] USED  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] src_i,
  input  logic             mask_we,
  input  logic             clr_we,
  input  logic [GRP_W-1:0] wdata,
  output logic [GRP_W-1:0] status_o,
  output logic [GRP_W-1:0] mask_o,
  output logic [GRP_W-1:0] req_o
);
  logic [GRP_W-1:0] mask_q;
  logic [GRP_W-1:0] src_used;

  assign src_used = src_i & USED;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata & USED;
  end

  generate
    if (STICKY) begin : g_sticky
      logic [GRP_W-1:0] stat_q;
      logic [GRP_W-1:0] clr_bits;
      assign clr_bits = clr_we ? wdata : '0;
      always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= sticky_next(stat_q, clr_bits, src_used);
      end
      assign status_o = stat_q;
    end else begin : g_level
      logic unused_clr;
      assign unused_clr = clr_we;
      assign status_o = src_used;
    end
  endgenerate

  assign mask_o = mask_q;
  assign req_o  = status_o & mask_q;
endmodule

// File: rtl/birq_resolver.sv
module birq_resolver
  import birq_pkg::*;
(
  input  logic [GRP_W-1:0] req_a,
  input  logic [GRP_W-1:0] req_b,
  input  logic [GRP_W-1:0] req_d,
  output logic [7:0]       vec_o
);
  logic [SEL_W-1:0] win_a, win_b, win_d;

  assign win_a = rank_pick(req_a, RANK_A);
  assign win_b = rank_pick(req_b, RANK_B);
  assign win_d = rank_pick(req_d, RANK_DMA);

  always_comb begin
    if (|req_b)      vec_o = NUM_BASE_B   + 8'(win_b);
    else if (|req_d) vec_o = NUM_BASE_DMA + 8'(win_d);
    else if (|req_a) vec_o = NUM_BASE_A   + 8'(win_a);
    else             vec_o = 8'd0;
  end
endmodule

// File: rtl/birq_ctrl.sv
module birq_ctrl
  import birq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        src_a_i,
  input  logic [7:0]        src_b_i,
  input  logic [5:0]        src_dma_i,
  input  logic [7:0]        src_fiq_i,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int OFF_W = 4;
  localparam int SEL_HI = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] OFF_STAT = 4'h0;
  localparam logic [OFF_W-1:0] OFF_REQ  = 4'h4;
  localparam logic [OFF_W-1:0] OFF_MASK = 4'h8;
  localparam logic [ADDR_W-1:0] VEC_ADDR = '0;

  logic [SEL_HI-1:0] grp_field;
  logic [OFF_W-1:0]  off_field;
  assign grp_field = bus_addr[ADDR_W-1:OFF_W];
  assign off_field = bus_addr[OFF_W-1:0];

  logic [GRP_W-1:0] src_all  [NUM_GRP];
  logic [GRP_W-1:0] stat_all [NUM_GRP];
  logic [GRP_W-1:0] mask_all [NUM_GRP];
  logic [GRP_W-1:0] req_all  [NUM_GRP];
  logic [NUM_GRP-1:0] hit, mask_stb, clr_stb;

  assign src_all[GRP_A]   = src_a_i;
  assign src_all[GRP_B]   = src_b_i;
  assign src_all[GRP_DMA] = {2'b00, src_dma_i};
  assign src_all[GRP_FIQ] = src_fiq_i;

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      assign hit[g]      = (grp_field == SEL_HI'(g + 1));
      assign mask_stb[g] = bus_we && hit[g] && (off_field == OFF_MASK);
      assign clr_stb[g]  = bus_we && hit[g] && (off_field == OFF_REQ);
      birq_group #(
        .STICKY (grp_sticky(g)),
        .USED   (grp_used(g))
      ) u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_all[g]),
        .mask_we  (mask_stb[g]),
        .clr_we   (clr_stb[g]),
        .wdata    (bus_wdata),
        .status_o (stat_all[g]),
        .mask_o   (mask_all[g]),
        .req_o    (req_all[g])
      );
    end
  endgenerate

  // Named internal events for the checker
  logic             clr_stb_a;
  logic [GRP_W-1:0] stat_a, req_a, req_b, req_d, req_f;
  logic [GRP_W-1:0] mask_a, mask_b, mask_d, mask_f;
  logic [7:0]       vec_now;

  assign clr_stb_a = clr_stb[GRP_A];
  assign stat_a    = stat_all[GRP_A];
  assign req_a     = req_all[GRP_A];
  assign req_b     = req_all[GRP_B];
  assign req_d     = req_all[GRP_DMA];
  assign req_f     = req_all[GRP_FIQ];
  assign mask_a    = mask_all[GRP_A];
  assign mask_b    = mask_all[GRP_B];
  assign mask_d    = mask_all[GRP_DMA];
  assign mask_f    = mask_all[GRP_FIQ];

  birq_resolver u_res (
    .req_a (req_a),
    .req_b (req_b),
    .req_d (req_d),
    .vec_o (vec_now)
  );

  assign irq_o = |{req_a, req_b, req_d};
  assign fiq_o = |req_f;

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == VEC_ADDR) rd_mux = vec_now;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (hit[g]) begin
        case (off_field)
          OFF_STAT: rd_mux = stat_all[g];
          OFF_REQ:  rd_mux = req_all[g];
          OFF_MASK: rd_mux = mask_all[g];
          default:  rd_mux = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= 8'h00;
    else        bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/birq_checker.sv
module birq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] src_a,
  input logic [7:0] wdata,
  input logic       clr_stb_a,
  input logic [7:0] stat_a,
  input logic [7:0] req_a,
  input logic [7:0] req_b,
  input logic [7:0] req_d,
  input logic [7:0] req_f,
  input logic [7:0] mask_a,
  input logic [7:0] mask_b,
  input logic [7:0] mask_d,
  input logic [7:0] mask_f,
  input logic [7:0] vec_now,
  input logic       irq_o
);
  assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (mask_a == 8'h00 && mask_b == 8'h00 && mask_d == 8'h00 && mask_f == 8'h00));

  assert_sticky_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a != 8'h00) |=> ((stat_a & $past(src_a)) == $past(src_a)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb_a |=> ((stat_a & $past(wdata & ~src_a)) == 8'h00));

  assert_grp_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_b != 8'h00) |-> (vec_now >= 8'd8 && vec_now <= 8'd15));

  assert_dma_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_b == 8'h00 && req_d != 8'h00) |-> (vec_now >= 8'd16 && vec_now <= 8'd21));

  assert_vec_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_now != 8'd0) |-> irq_o);

  assert_fiq_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_f != 8'h00 && req_a == 8'h00 && req_b == 8'h00 && req_d == 8'h00) |-> !irq_o);
endmodule

bind birq_ctrl birq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_a     (src_a_i),
  .wdata     (bus_wdata),
  .clr_stb_a (clr_stb_a),
  .stat_a    (stat_a),
  .req_a     (req_a),
  .req_b     (req_b),
  .req_d     (req_d),
  .req_f     (req_f),
  .mask_a    (mask_a),
  .mask_b    (mask_b),
  .mask_d    (mask_d),
  .mask_f    (mask_f),
  .vec_now   (vec_now),
  .irq_o     (irq_o)
);

// File: tb/sim_birq_ctrl.sv
module sim_birq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] src_a = 8'h00, src_b = 8'h00, src_fiq = 8'h00;
  logic [5:0] src_dma = 6'h00;
  logic       irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  birq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .src_a_i(src_a), .src_b_i(src_b),
    .src_dma_i(src_dma), .src_fiq_i(src_fiq), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  localparam logic [7:0] A_VEC = 8'h00;
  localparam logic [7:0] A_ST  = 8'h10, A_CL = 8'h14, A_MK = 8'h18;
  localparam logic [7:0] B_ST  = 8'h20, B_CL = 8'h24, B_MK = 8'h28;
  localparam logic [7:0] D_ST  = 8'h30, D_RQ = 8'h34, D_MK = 8'h38;
  localparam logic [7:0] F_ST  = 8'h40, F_RQ = 8'h44, F_MK = 8'h48;

  // {irq, grpB, dma, grpA, vector}
  localparam int NV = 14;
  localparam logic [32:0] TBL [NV] = '{
    {1'b0, 8'h00, 8'h00, 8'h00, 8'd0},
    {1'b1, 8'h11, 8'h00, 8'h00, 8'd8},
    {1'b1, 8'h84, 8'h3F, 8'hFF, 8'd10},
    {1'b1, 8'h50, 8'h00, 8'h00, 8'd14},
    {1'b1, 8'h00, 8'h30, 8'h00, 8'd21},
    {1'b1, 8'h00, 8'h10, 8'h80, 8'd20},
    {1'b1, 8'h00, 8'h0C, 8'h00, 8'd18},
    {1'b1, 8'h00, 8'h00, 8'h53, 8'd6},
    {1'b1, 8'h00, 8'h00, 8'h13, 8'd0},
    {1'b1, 8'h00, 8'h00, 8'h12, 8'd1},
    {1'b1, 8'h00, 8'h00, 8'h10, 8'd4},
    {1'b1, 8'h00, 8'h00, 8'hA0, 8'd7},
    {1'b1, 8'h00, 8'h00, 8'h28, 8'd5},
    {1'b1, 8'hC3, 8'h00, 8'h00, 8'd15}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 fiq", {7'd0, fiq_o}, 8'h00);
    rd(A_MK, v); chk("R1 maskA", v, 8'h00);
    rd(D_MK, v); chk("R1 maskDMA", v, 8'h00);

    // R3 masked source: status visible, no request, no line
    src_b = 8'h04;
    rd(B_ST, v); chk("R3 statusB", v, 8'h04);
    rd(B_CL, v); chk("R3 reqB masked", v, 8'h00);
    chk("R3 irq masked", {7'd0, irq_o}, 8'h00);
    src_b = 8'h00;

    // enable everything
    wr(A_MK, 8'hFF); wr(B_MK, 8'hFF); wr(D_MK, 8'hFF); wr(F_MK, 8'hFF);
    rd(B_MK, v); chk("R2 maskB readback", v, 8'hFF);
    // R6 DMA high bits
    rd(D_MK, v); chk("R6 maskDMA", v, 8'h3F);
    src_dma = 6'h3F;
    rd(D_ST, v); chk("R6 statusDMA", v, 8'h3F);
    rd(D_RQ, v); chk("R6 reqDMA", v, 8'h3F);
    src_dma = 6'h00;
    rd(8'h5C, v); chk("R2 unmapped", v, 8'h00);

    // Vector table: R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_b = TBL[i][31:24]; src_dma = TBL[i][21:16]; src_a = TBL[i][15:8];
      bus_addr = A_VEC;
      @(negedge clk);
      src_a = 8'h00;
      @(negedge clk);
      chk("R7 R8 R9 R10 vector", bus_rdata, TBL[i][7:0]);
      chk("R11 irq line", {7'd0, irq_o}, {7'd0, TBL[i][32]});
      src_b = 8'h00; src_dma = 6'h00;
      wr(A_CL, 8'hFF);
    end

    // R4 sticky, clear, and live input wins
    @(negedge clk); src_a = 8'h24;
    @(negedge clk); src_a = 8'h00;
    rd(A_ST, v); chk("R4 sticky held", v, 8'h24);
    wr(A_CL, 8'h04);
    rd(A_ST, v); chk("R4 clear one bit", v, 8'h20);
    @(negedge clk);
    src_a = 8'h20; bus_addr = A_CL; bus_wdata = 8'h20; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; src_a = 8'h00;
    rd(A_ST, v); chk("R4 input beats clear", v, 8'h20);

    // R12 vector read has no side effect
    rd(A_VEC, v); rd(A_VEC, v2);
    chk("R12 vector first", v, 8'd5);
    chk("R12 vector repeat", v2, 8'd5);
    rd(A_ST, v); chk("R12 status kept", v, 8'h20);
    wr(A_CL, 8'hFF);
    rd(A_ST, v); chk("R4 cleared", v, 8'h00);

    // R5 clear ignored on level groups
    src_b = 8'h81;
    wr(B_CL, 8'hFF);
    rd(B_ST, v); chk("R5 statusB after clear", v, 8'h81);
    src_b = 8'h00;
    rd(B_ST, v); chk("R5 statusB follows", v, 8'h00);

    // R11 fast group
    src_fiq = 8'h40;
    rd(F_RQ, v); chk("R11 reqFIQ", v, 8'h40);
    chk("R11 fiq high", {7'd0, fiq_o}, 8'h01);
    chk("R11 irq low", {7'd0, irq_o}, 8'h00);
    rd(A_VEC, v); chk("R7 fiq not in vector", v, 8'h00);
    wr(F_MK, 8'h00);
    chk("R3 fiq masked", {7'd0, fiq_o}, 8'h00);
    rd(F_ST, v); chk("R5 statusFIQ", v, 8'h40);
    src_fiq = 8'h00;

    finish_run();
  end
endmodule